// File: doc/BRIEF.md
# Sprite Attribute Memory Copy Engine

This block moves a fixed run of 160 bytes from a CPU-visible 256-byte page into sprite attribute memory. Software starts a copy by writing the high byte of the source address. The engine then reads the page one byte at a time through a source read port and writes each byte to the sprite memory write port. Pacing comes from a cycle tick: the first byte lands eight ticks after the start, and every later byte four ticks after the one before it.

While a copy runs, the CPU is shut out of part of the address space. Sprite memory itself is always off limits. A second window, which depends on the hardware model and on the top three bits of the source address, is also shut. A blocked read returns 0xFF and a blocked write never reaches memory. When the final byte has been written, the lock lifts. A new start request during a copy abandons the old copy and begins again from the new page.

Top module: `spr_dma`

## Requirements
- R1: A start request whose base byte is above 0xF1 is ignored: an idle engine stays idle and nothing is written.
- R2: The first sprite write happens on the 8th tick after the clock edge that accepts a start request. Cycles with `tick` low do not count.
- R3: Each later sprite write happens exactly 4 ticks after the previous one.
- R4: A copy makes exactly 160 writes. `spr_idx` runs from 0 to 159, `src_addr` equals base*256 + `spr_idx` during each write, and `spr_wdata` equals `src_rdata` in that same cycle.
- R5: `active` goes high on the edge that accepts a start and falls on the edge that performs the 160th write.
- R6: While a CPU access is blocked (`cpu_block` high), a read returns 0xFF on `cpu_rdata` and `mem_wr` stays low. An access that is not blocked passes `mem_rdata` and `cpu_wr` through unchanged.
- R7: While `active` is high, CPU accesses to 0xFE00–0xFE9F are always blocked.
- R8: With `color_model` low (monochrome), a source address with bits [15:13] = 4 blocks 0x8000–0x9FFF. Any other value blocks 0xA000–0xFDFF.
- R9: With `color_model` high, bits [15:13] = 4 block 0x8000–0x9FFF, bits [15:13] = 6 block 0xC000–0xFDFF, and all other values block 0xA000–0xBFFF.
- R10: While idle, `cpu_block` and `spr_we` are low. After reset the engine is idle.
- R11: An accepted start during a copy restarts it: the index returns to 0, the source becomes the new page, and the first write again comes 8 ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle enable that paces the copy |
| trig | input | 1 | Start request strobe |
| trig_base | input | 8 | High byte of the source page |
| color_model | input | 1 | 0 = monochrome lock table, 1 = color lock table |
| active | output | 1 | Copy in progress |
| src_addr | output | 16 | Source read address |
| src_rdata | input | 8 | Source data, valid in the same cycle |
| spr_we | output | 1 | Sprite memory write strobe |
| spr_idx | output | 8 | Sprite memory byte index |
| spr_wdata | output | 8 | Sprite memory write data |
| cpu_addr | input | 16 | CPU access address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| mem_rdata | input | 8 | Read data from the normal bus |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| mem_wr | output | 1 | Write strobe forwarded to the normal bus |
| cpu_block | output | 1 | Current CPU access is blocked |

## Verification
Lock windows are checked with source pages from regions 0, 2, 4, 6 and 7 under both models. CPU addresses sit just inside and just outside each window edge, so a wrong table row or an off-by-one bound shows up. Copy pacing is checked cycle by cycle over a full run with a source pattern that mixes the high and low address bytes; this catches a wrong start value, a skipped index or a count that stops early or late. Further runs hold `tick` low, retrigger in the middle of a copy, and use the accepted base 0xF1 next to the rejected 0xF2.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

   typedef enum logic {
      MODEL_MONO  = 1'b0,
      MODEL_COLOR = 1'b1
   } hw_model_e;

   // half-open address span [lo, hi)
   typedef struct packed {
      logic [15:0] lo;
      logic [15:0] hi;
   } span_t;

   // CPU lock-out window chosen by model and source region bits [15:13]
   function automatic span_t lock_span(input hw_model_e model, input logic [2:0] rgn);
      span_t s;
      if (rgn == 3'd4)
         s = '{lo: 16'h8000, hi: 16'hA000};
      else if (model == MODEL_COLOR && rgn == 3'd6)
         s = '{lo: 16'hC000, hi: 16'hFE00};
      else if (model == MODEL_COLOR)
         s = '{lo: 16'hA000, hi: 16'hC000};
      else
         s = '{lo: 16'hA000, hi: 16'hFE00};
      return s;
   endfunction

endpackage

// File: rtl/spr_dma_seq.sv
module spr_dma_seq #(
   parameter int ADDR_W   = 16,
   parameter int PAGE_W   = 8,
   parameter int IDX_W    = 8,
   parameter int XFER_LEN = 160,
   parameter int LEAD     = 8,
   parameter int GAP      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic [PAGE_W-1:0] start_page,
   output logic              busy,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              wr_now
);
   localparam int CNT_MAX = (LEAD > GAP) ? LEAD : GAP;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int LOW_W   = ADDR_W - PAGE_W;

   logic              busy_q;
   logic [CNT_W-1:0]  wait_q;
   logic [ADDR_W-1:0] addr_q;
   logic [IDX_W-1:0]  idx_q;
   logic              due;

   assign due    = busy_q && tick && (wait_q == CNT_W'(1));
   assign wr_now = due && !start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wait_q <= '0;
         addr_q <= '0;
         idx_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         wait_q <= CNT_W'(LEAD);
         addr_q <= {start_page, {LOW_W{1'b0}}};
         idx_q  <= '0;
      end else if (busy_q && tick) begin
         if (due) begin
            wait_q <= CNT_W'(GAP);
            addr_q <= addr_q + ADDR_W'(1);
            idx_q  <= idx_q + IDX_W'(1);
            if (idx_q == IDX_W'(XFER_LEN - 1))
               busy_q <= 1'b0;
         end else begin
            wait_q <= wait_q - CNT_W'(1);
         end
      end
   end

   assign busy    = busy_q;
   assign rd_addr = addr_q;
   assign wr_idx  = idx_q;

endmodule

// File: rtl/spr_dma_guard.sv
module spr_dma_guard
   import spr_dma_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter bit COLOR_CAPABLE = 1'b1,
   parameter int OAM_LO        = 'hFE00,
   parameter int OAM_HI        = 'hFEA0
) (
   input  logic              busy,
   input  logic [2:0]        src_rgn,
   input  logic              color_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output logic              block
);
   hw_model_e model;
   span_t     win;
   logic      in_win, in_oam;

   generate
      if (COLOR_CAPABLE) begin : g_two_model
         assign model = color_sel ? MODEL_COLOR : MODEL_MONO;
      end else begin : g_mono_only
         logic unused_sel;
         assign unused_sel = color_sel;
         assign model = MODEL_MONO;
      end
   endgenerate

   assign win    = lock_span(model, src_rgn);
   assign in_win = (addr >= win.lo) && (addr < win.hi);
   assign in_oam = (addr >= ADDR_W'(OAM_LO)) && (addr < ADDR_W'(OAM_HI));
   assign block  = busy && (rd || wr) && (in_win || in_oam);

endmodule

// File: rtl/spr_dma.sv
module spr_dma #(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int PAGE_W        = 8,
   parameter int XFER_LEN      = 160,
   parameter int IDX_W         = $clog2(XFER_LEN),
   parameter int LEAD          = 8,
   parameter int GAP           = 4,
   parameter int MAX_BASE      = 'hF1,
   parameter bit COLOR_CAPABLE = 1'b1,
   parameter int OAM_LO        = 'hFE00,
   parameter int OAM_HI        = 'hFEA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              trig,
   input  logic [PAGE_W-1:0] trig_base,
   input  logic              color_model,
   output logic              active,
   output logic [ADDR_W-1:0] src_addr,
   input  logic [DATA_W-1:0] src_rdata,
   output logic              spr_we,
   output logic [IDX_W-1:0]  spr_idx,
   output logic [DATA_W-1:0] spr_wdata,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_wr,
   output logic              cpu_block
);
   generate
      if (ADDR_W != 16) begin : g_bad_addr
         $error("spr_dma: lock tables assume a 16-bit address");
      end
      if (PAGE_W >= ADDR_W) begin : g_bad_page
         $error("spr_dma: page width must be below address width");
      end
      if (LEAD < 1 || GAP < 1) begin : g_bad_pace
         $error("spr_dma: LEAD and GAP must be at least 1");
      end
      if (XFER_LEN < 1 || XFER_LEN > (1 << IDX_W)) begin : g_bad_len
         $error("spr_dma: XFER_LEN does not fit IDX_W");
      end
   endgenerate

   logic accept;
   assign accept = trig && (trig_base <= PAGE_W'(MAX_BASE));

   spr_dma_seq #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W),
      .XFER_LEN(XFER_LEN), .LEAD(LEAD), .GAP(GAP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .start(accept), .start_page(trig_base),
      .busy(active), .rd_addr(src_addr), .wr_idx(spr_idx), .wr_now(spr_we)
   );

   spr_dma_guard #(
      .ADDR_W(ADDR_W), .COLOR_CAPABLE(COLOR_CAPABLE),
      .OAM_LO(OAM_LO), .OAM_HI(OAM_HI)
   ) u_guard (
      .busy(active), .src_rgn(src_addr[ADDR_W-1 -: 3]), .color_sel(color_model),
      .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .block(cpu_block)
   );

   assign spr_wdata = src_rdata;
   assign cpu_rdata = (cpu_block && cpu_rd) ? {DATA_W{1'b1}} : mem_rdata;
   assign mem_wr    = cpu_wr && !cpu_block;

endmodule

// File: rtl/spr_dma_chk.sv
module spr_dma_chk #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int PAGE_W   = 8,
   parameter int IDX_W    = 8,
   parameter int XFER_LEN = 160,
   parameter int MAX_BASE = 'hF1,
   parameter int OAM_LO   = 'hFE00,
   parameter int OAM_HI   = 'hFEA0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig,
   input logic [PAGE_W-1:0] trig_base,
   input logic              active,
   input logic              spr_we,
   input logic [IDX_W-1:0]  spr_idx,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              mem_wr,
   input logic              cpu_block
);
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!spr_we && !cpu_block));

   // R6
   blocked_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_block |-> !mem_wr);

   // R6
   blocked_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_block && cpu_rd) |-> (cpu_rdata == {DATA_W{1'b1}}));

   // R7
   oam_always_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (cpu_rd || cpu_wr) && cpu_addr >= ADDR_W'(OAM_LO)
       && cpu_addr < ADDR_W'(OAM_HI)) |-> cpu_block);

   // R5
   start_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && trig_base <= PAGE_W'(MAX_BASE)) |=> (active && spr_idx == '0));

   // R1
   high_base_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && trig && trig_base > PAGE_W'(MAX_BASE)) |=> !active);

   // R4
   last_write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spr_we && spr_idx == IDX_W'(XFER_LEN - 1)) |=> (!active || $past(trig)));

endmodule

bind spr_dma spr_dma_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W),
   .XFER_LEN(XFER_LEN), .MAX_BASE(MAX_BASE), .OAM_LO(OAM_LO), .OAM_HI(OAM_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .trig(trig), .trig_base(trig_base),
   .active(active), .spr_we(spr_we), .spr_idx(spr_idx),
   .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
   .cpu_rdata(cpu_rdata), .mem_wr(mem_wr), .cpu_block(cpu_block)
);

// File: tb/tb_spr_dma.sv
`timescale 1ns/1ps
module tb_spr_dma;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        trig = 1'b0;
   logic [7:0]  trig_base = 8'h00;
   logic        color_model = 1'b0;
   logic        active;
   logic [15:0] src_addr;
   logic [7:0]  src_rdata;
   logic        spr_we;
   logic [7:0]  spr_idx;
   logic [7:0]  spr_wdata;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  mem_rdata = 8'h3C;
   logic [7:0]  cpu_rdata;
   logic        mem_wr;
   logic        cpu_block;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [7:0] pat(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   assign src_rdata = pat(src_addr);

   spr_dma dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig), .trig_base(trig_base),
      .color_model(color_model), .active(active), .src_addr(src_addr),
      .src_rdata(src_rdata), .spr_we(spr_we), .spr_idx(spr_idx),
      .spr_wdata(spr_wdata), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
      .cpu_wr(cpu_wr), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
      .mem_wr(mem_wr), .cpu_block(cpu_block)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // returns at the first falling edge after the accepting edge
   task automatic start(input logic [7:0] base);
      @(negedge clk);
      trig = 1'b1;
      trig_base = base;
      @(negedge clk);
      trig = 1'b0;
   endtask

   // cycle-by-cycle check of a copy from page base, sample n=1 is now
   task automatic run_xfer(input logic [7:0] base, input int nlast);
      for (int n = 1; n <= nlast; n++) begin
         bit exp_we;
         int k;
         if (n > 1) @(negedge clk);
         exp_we = (n >= 8) && ((n - 8) % 4 == 0) && (n <= 644);
         k = (n - 8) / 4;
         chk(spr_we == exp_we, "R2/R3 write timing", spr_we, exp_we);
         chk(active == (n <= 644), "R5 active span", active, (n <= 644));
         if (exp_we) begin
            chk(spr_idx == k[7:0], "R4 index", spr_idx, k);
            chk(src_addr == {base, 8'h00} + 16'(k), "R4 source", src_addr, {base, 8'h00} + 16'(k));
            chk(spr_wdata == pat({base, 8'h00} + 16'(k)), "R4 data", spr_wdata,
                pat({base, 8'h00} + 16'(k)));
         end
      end
   endtask

   // {color, base, cpu address, expected block}
   localparam int NV = 20;
   localparam logic [25:0] VEC [NV] = '{
      {1'b0, 8'h80, 16'h8000, 1'b1}, {1'b0, 8'h80, 16'h9FFF, 1'b1},
      {1'b0, 8'h80, 16'hA000, 1'b0}, {1'b0, 8'hC0, 16'hA000, 1'b1},
      {1'b0, 8'hC0, 16'hFDFF, 1'b1}, {1'b0, 8'hC0, 16'h8000, 1'b0},
      {1'b0, 8'hC0, 16'hFE00, 1'b1}, {1'b0, 8'hC0, 16'hFEA0, 1'b0},
      {1'b0, 8'h00, 16'hC000, 1'b1}, {1'b1, 8'h80, 16'h9FFF, 1'b1},
      {1'b1, 8'h80, 16'hA000, 1'b0}, {1'b1, 8'hC0, 16'hC000, 1'b1},
      {1'b1, 8'hC0, 16'hBFFF, 1'b0}, {1'b1, 8'hC0, 16'hFDFF, 1'b1},
      {1'b1, 8'h40, 16'hA000, 1'b1}, {1'b1, 8'h40, 16'hBFFF, 1'b1},
      {1'b1, 8'h40, 16'hC000, 1'b0}, {1'b1, 8'h40, 16'hFE9F, 1'b1},
      {1'b1, 8'hE0, 16'hB000, 1'b1}, {1'b1, 8'hE0, 16'hFE00, 1'b1}
   };

   task automatic wait_idle();
      for (int i = 0; i < 1000 && active; i++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(active == 1'b0, "R10 reset active", active, 0);
      chk(spr_we == 1'b0, "R10 reset write", spr_we, 0);
      rst_n = 1'b1;
      cpu_addr = 16'hFE10; cpu_rd = 1'b1; #1;
      chk(cpu_block == 1'b0, "R10 idle no block", cpu_block, 0);
      chk(cpu_rdata == 8'h3C, "R6 idle pass", cpu_rdata, 8'h3C);
      cpu_rd = 1'b0;

      // lock window table (R7 R8 R9)
      for (int v = 0; v < NV; v++) begin
         logic [25:0] e;
         e = VEC[v];
         color_model = e[25];
         start(e[24:17]);
         cpu_addr = e[16:1]; cpu_rd = 1'b1; #1;
         chk(cpu_block == e[0], e[25] ? "R9 color window" : "R8 mono window", cpu_block, e[0]);
         chk(cpu_rdata == (e[0] ? 8'hFF : 8'h3C), "R6 read data", cpu_rdata, e[0] ? 8'hFF : 8'h3C);
         cpu_rd = 1'b0;
      end
      wait_idle();

      // full copy, monochrome, page 0x80 (R2 R3 R4 R5)
      color_model = 1'b0;
      start(8'h80);
      run_xfer(8'h80, 650);

      // blocked writes and restore after completion (R6 R10)
      start(8'hC0);
      run_xfer(8'hC0, 30);
      cpu_addr = 16'hA123; cpu_wr = 1'b1; #1;
      chk(mem_wr == 1'b0, "R6 blocked write", mem_wr, 0);
      cpu_addr = 16'h2000; #1;
      chk(mem_wr == 1'b1, "R6 open write", mem_wr, 1);
      cpu_wr = 1'b0;
      wait_idle();
      @(negedge clk);
      cpu_addr = 16'hA123; cpu_rd = 1'b1; cpu_wr = 1'b1; #1;
      chk(cpu_block == 1'b0, "R10 lock lifted", cpu_block, 0);
      chk(cpu_rdata == 8'h3C && mem_wr == 1'b1, "R10 access restored", cpu_rdata, 8'h3C);
      cpu_rd = 1'b0; cpu_wr = 1'b0;

      // R1: rejected and boundary base
      start(8'hF2);
      repeat (12) @(negedge clk);
      chk(active == 1'b0 && spr_we == 1'b0, "R1 base F2 ignored", active, 0);
      start(8'hF1);
      chk(active == 1'b1, "R1 base F1 accepted", active, 1);
      wait_idle();

      // R2: ticks low stall the lead-in
      tick = 1'b0;
      start(8'h10);
      for (int i = 0; i < 20; i++) begin
         chk(spr_we == 1'b0 && active == 1'b1, "R2 stalled without tick", spr_we, 0);
         @(negedge clk);
      end
      tick = 1'b1;
      run_xfer(8'h10, 12);
      wait_idle();

      // R11: restart mid-copy
      start(8'hC0);
      run_xfer(8'hC0, 22);
      start(8'h40);
      run_xfer(8'h40, 650);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule